// File: doc/BRIEF.md
# Search Coprocessor Command and Result Bus Front End

This block is the slave-side front end of a search coprocessor attached to a synchronous SRAM-style bus. The host builds each command from one or more ordinary bus writes. Each write lands in a per-slot context as one beat of opcode, key or associated-data operation. The write that carries the last-beat address flag completes the command. On that write, the slot's collected beats are handed to the lookup pipeline in a single-cycle dispatch pulse.

The pipeline later returns a result word group for the slot. The block stores it in a read-addressable result buffer and marks the slot done. The host polls a status word and fetches any subset of the result words with ordinary pipelined reads that have one cycle of latency. Every slot runs independently, so as many commands as there are slots can be in flight at once. A write aimed at a slot whose command is still in flight is discarded and raises a sticky error flag.

Top module: `scf_front`

## Requirements
- R1: After reset, every slot is neither busy nor done, the error flag is clear, and `disp_valid` and `bus_rvalid` are low.
- R2: A write (`bus_en`=1, `bus_we`=1) with address bit 5 = 0 is a command beat. Bits [3:2] select the slot, bits [1:0] select the beat and bit 4 is the last-beat flag. A beat written with bit 4 = 0 is stored and does not dispatch.
- R3: A command-beat write with bit 4 = 1 to a slot that is not busy stores that beat. In the next cycle it raises `disp_valid` for exactly one cycle, with `disp_slot` = slot, `disp_len` = beat index + 1, and beat i of the slot on `disp_data[i*32 +: 32]`.
- R4: A slot is busy from its dispatch until its result arrives, and slots are busy independently of one another.
- R5: A command-beat write to a busy slot is dropped. It causes no dispatch and leaves the slot's stored beats unchanged.
- R6: A dropped write sets the error flag, and the flag stays set until reset.
- R7: `res_valid` with `res_slot` naming a busy slot stores word w from `res_data[w*32 +: 32]`, sets done and clears busy. A result for a slot that is not busy is ignored.
- R8: A read (`bus_en`=1, `bus_we`=0) with bit 5 = 1 returns result word bits [1:0] of slot bits [3:2] on `bus_rdata`, with `bus_rvalid` high, in the cycle after the address. Word indices of 2 or more read as zero.
- R9: A read with bit 5 = 0 returns the status word one cycle later. Bits [3:0] are the done flags, bits [7:4] are the busy flags, bit 31 is the error flag and all other bits are zero.
- R10: The first accepted command-beat write to a done slot clears that slot's done flag.
- R11: Reads and writes can be issued on consecutive cycles with no idle cycle between them.
- R12: A write with bit 5 = 1 has no effect on any slot, result word, flag or dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus transaction valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | {space, last, slot[1:0], index[1:0]} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| bus_rvalid | output | 1 | bus_rdata holds a read result |
| disp_valid | output | 1 | Command dispatch pulse |
| disp_slot | output | 2 | Slot being dispatched |
| disp_len | output | 3 | Number of beats in the command |
| disp_data | output | 128 | All beats of the dispatched slot |
| res_valid | input | 1 | Pipeline returns a result |
| res_slot | input | 2 | Slot the result belongs to |
| res_data | input | 64 | Result words |

## Verification
The bench sweeps every slot with every command length. It checks that only the flagged beat dispatches: a design that dispatched early, or held `disp_valid` for more than one cycle, would produce a wrong beat count. It writes into in-flight slots, including with the last flag set, and catches a design that overwrote the held beats, re-dispatched, or failed to latch the error. It also returns results for idle slots, issues writes to the result space, and reads past the valid word range. Each of these would show up as corrupted result words or phantom done bits. Back-to-back status reads after each first beat confirm that done clears on reuse, not on read.

// File: rtl/scf_pkg.sv
package scf_pkg;

    typedef enum logic [1:0] {
        OP_NONE      = 2'd0,
        OP_CMD_WR    = 2'd1,
        OP_RD_STATUS = 2'd2,
        OP_RD_RESULT = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     last;
    } bus_op_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/scf_decode.sv
module scf_decode
    import scf_pkg::*;
#(
    parameter int SLOT_W = 2,
    parameter int IDX_W  = 2,
    localparam int ADDR_W = IDX_W + SLOT_W + 2
) (
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output bus_op_t           op,
    output logic [SLOT_W-1:0] slot,
    output logic [IDX_W-1:0]  idx
);
    logic space_res;

    always_comb begin
        space_res = addr[ADDR_W-1];
        slot      = addr[IDX_W +: SLOT_W];
        idx       = addr[IDX_W-1:0];
        op.last   = addr[ADDR_W-2];
        op.kind   = OP_NONE;
        if (en) begin
            if (we) op.kind = space_res ? OP_NONE : OP_CMD_WR;
            else    op.kind = space_res ? OP_RD_RESULT : OP_RD_STATUS;
        end
    end
endmodule

// File: rtl/scf_slot.sv
module scf_slot #(
    parameter int BEATS     = 4,
    parameter int RES_WORDS = 2,
    parameter int DATA_W    = 32,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_hit,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic                        wr_last,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        res_hit,
    input  logic [RES_WORDS*DATA_W-1:0] res_data,
    output logic                        busy,
    output logic                        done,
    output logic [BEATS*DATA_W-1:0]     beats_flat,
    output logic [RES_WORDS*DATA_W-1:0] res_flat,
    output logic                        launch,
    output logic                        drop
);
    logic accept;
    logic take_res;

    assign accept   = wr_hit && !busy;
    assign launch   = accept && wr_last;
    assign drop     = wr_hit && busy;
    assign take_res = res_hit && busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            if (launch)        busy <= 1'b1;
            else if (take_res) busy <= 1'b0;
            if (accept)        done <= 1'b0;
            else if (take_res) done <= 1'b1;
        end
    end

    for (genvar g = 0; g < BEATS; g++) begin : g_beat
        always_ff @(posedge clk) begin
            if (rst)
                beats_flat[g*DATA_W +: DATA_W] <= '0;
            else if (accept && int'(wr_idx) == g)
                beats_flat[g*DATA_W +: DATA_W] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           res_flat <= '0;
        else if (take_res) res_flat <= res_data;
    end

    AST_DROP_KEEPS_BEATS: assert property (@(posedge clk) disable iff (rst)
        drop |=> $stable(beats_flat)); // R5
    AST_DONE_EXCLUDES_BUSY: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R7
    AST_RESULT_COMPLETES: assert property (@(posedge clk) disable iff (rst)
        take_res |=> (done && !busy)); // R7
    AST_IDLE_RESULT_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (res_hit && !busy) |=> $stable(res_flat)); // R7
endmodule

// File: rtl/scf_rdmux.sv
module scf_rdmux
    import scf_pkg::*;
#(
    parameter int SLOTS     = 4,
    parameter int RES_WORDS = 2,
    parameter int DATA_W    = 32,
    parameter int SLOT_W    = 2,
    parameter int IDX_W     = 2
) (
    input  op_kind_e                          kind,
    input  logic [SLOT_W-1:0]                 slot,
    input  logic [IDX_W-1:0]                  idx,
    input  logic [SLOTS-1:0]                  done_vec,
    input  logic [SLOTS-1:0]                  busy_vec,
    input  logic                              err,
    input  logic [SLOTS*RES_WORDS*DATA_W-1:0] res_all,
    output logic [DATA_W-1:0]                 word
);
    always_comb begin
        word = '0;
        if (kind == OP_RD_STATUS) begin
            word[SLOTS-1:0]       = done_vec;
            word[2*SLOTS-1:SLOTS] = busy_vec;
            word[DATA_W-1]        = err;
        end else if (kind == OP_RD_RESULT && int'(idx) < RES_WORDS) begin
            word = res_all[(int'(slot)*RES_WORDS + int'(idx))*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/scf_front.sv
module scf_front
    import scf_pkg::*;
#(
    parameter int SLOTS     = 4,
    parameter int BEATS     = 4,
    parameter int RES_WORDS = 2,
    parameter int DATA_W    = 32,
    localparam int SLOT_W   = $clog2(SLOTS),
    localparam int IDX_W    = $clog2(max2(BEATS, RES_WORDS)),
    localparam int ADDR_W   = IDX_W + SLOT_W + 2,
    localparam int LEN_W    = $clog2(BEATS + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_en,
    input  logic                        bus_we,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        bus_rvalid,
    output logic                        disp_valid,
    output logic [SLOT_W-1:0]           disp_slot,
    output logic [LEN_W-1:0]            disp_len,
    output logic [BEATS*DATA_W-1:0]     disp_data,
    input  logic                        res_valid,
    input  logic [SLOT_W-1:0]           res_slot,
    input  logic [RES_WORDS*DATA_W-1:0] res_data
);
    bus_op_t           dec_op;
    logic [SLOT_W-1:0] dec_slot;
    logic [IDX_W-1:0]  dec_idx;

    logic [SLOTS-1:0]                  busy_vec;
    logic [SLOTS-1:0]                  done_vec;
    logic [SLOTS-1:0]                  launch_vec;
    logic [SLOTS-1:0]                  drop_vec;
    logic [SLOTS*BEATS*DATA_W-1:0]     beats_all;
    logic [SLOTS*RES_WORDS*DATA_W-1:0] res_all;
    logic [DATA_W-1:0]                 rd_word;
    logic                              err;

    scf_decode #(.SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_dec (
        .en   (bus_en),
        .we   (bus_we),
        .addr (bus_addr),
        .op   (dec_op),
        .slot (dec_slot),
        .idx  (dec_idx)
    );

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic wr_hit;
        logic res_hit;
        assign wr_hit  = (dec_op.kind == OP_CMD_WR) && (int'(dec_slot) == s);
        assign res_hit = res_valid && (int'(res_slot) == s);

        scf_slot #(
            .BEATS(BEATS), .RES_WORDS(RES_WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)
        ) u_slot (
            .clk        (clk),
            .rst        (rst),
            .wr_hit     (wr_hit),
            .wr_idx     (dec_idx),
            .wr_last    (dec_op.last),
            .wr_data    (bus_wdata),
            .res_hit    (res_hit),
            .res_data   (res_data),
            .busy       (busy_vec[s]),
            .done       (done_vec[s]),
            .beats_flat (beats_all[s*BEATS*DATA_W +: BEATS*DATA_W]),
            .res_flat   (res_all[s*RES_WORDS*DATA_W +: RES_WORDS*DATA_W]),
            .launch     (launch_vec[s]),
            .drop       (drop_vec[s])
        );
    end

    scf_rdmux #(
        .SLOTS(SLOTS), .RES_WORDS(RES_WORDS), .DATA_W(DATA_W),
        .SLOT_W(SLOT_W), .IDX_W(IDX_W)
    ) u_rd (
        .kind     (dec_op.kind),
        .slot     (dec_slot),
        .idx      (dec_idx),
        .done_vec (done_vec),
        .busy_vec (busy_vec),
        .err      (err),
        .res_all  (res_all),
        .word     (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err        <= 1'b0;
            disp_valid <= 1'b0;
            disp_slot  <= '0;
            disp_len   <= '0;
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            if (|drop_vec) err <= 1'b1;
            disp_valid <= |launch_vec;
            if (|launch_vec) begin
                disp_slot <= dec_slot;
                disp_len  <= LEN_W'(int'(dec_idx) + 1);
            end
            bus_rvalid <= bus_en && !bus_we;
            bus_rdata  <= rd_word;
        end
    end

    assign disp_data = beats_all[int'(disp_slot)*BEATS*DATA_W +: BEATS*DATA_W];

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R6
    AST_DISP_SLOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> busy_vec[disp_slot]); // R4
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (bus_en && !bus_we) |=> bus_rvalid); // R8
    AST_SINGLE_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        $countones(launch_vec) <= 1); // R3
    AST_DROP_NO_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (|drop_vec) |=> !disp_valid); // R5
endmodule

// File: tb/scf_front_test.sv
module scf_front_test;
    logic         clk = 1'b0;
    logic         rst;
    logic         bus_en, bus_we;
    logic [5:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic         bus_rvalid;
    logic         disp_valid;
    logic [1:0]   disp_slot;
    logic [2:0]   disp_len;
    logic [127:0] disp_data;
    logic         res_valid;
    logic [1:0]   res_slot;
    logic [63:0]  res_data;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [31:0] mb [4][4];
    logic [31:0] mr [4][2];
    logic [3:0]  ex_busy, ex_done;
    logic        ex_err;
    logic [31:0] rd;

    always #10 clk = ~clk;

    scf_front uut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .disp_valid(disp_valid), .disp_slot(disp_slot),
        .disp_len(disp_len), .disp_data(disp_data), .res_valid(res_valid),
        .res_slot(res_slot), .res_data(res_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] mk(input bit sp, input bit last, input int s, input int i);
        return {sp, last, 2'(s), 2'(i)};
    endfunction

    function automatic logic [31:0] stat_exp();
        return {ex_err, 23'd0, ex_busy, ex_done};
    endfunction

    task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_en = 0;
    endtask

    task automatic bread(input logic [5:0] a, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_en = 0;
        d = bus_rdata;
        chk(bus_rvalid === 1'b1, "R8 rvalid", bus_rvalid, 1);
    endtask

    task automatic give_res(input int s, input logic [31:0] w0, input logic [31:0] w1);
        res_valid = 1; res_slot = 2'(s); res_data = {w1, w0};
        @(posedge clk); @(negedge clk);
        res_valid = 0;
        if (ex_busy[s]) begin
            mr[s][0] = w0; mr[s][1] = w1;
            ex_busy[s] = 0; ex_done[s] = 1;
        end
    endtask

    task automatic check_status(input string tag);
        bread(mk(0, 0, 0, 0), rd);
        chk(rd === stat_exp(), tag, rd, stat_exp());
    endtask

    task automatic send_cmd(input int s, input int n, input int it);
        for (int b = 0; b < n; b++) begin
            logic [31:0] d;
            bit last;
            d = 32'hA000_0000 | (s << 16) | (b << 8) | it;
            last = (b == n - 1);
            bwrite(mk(0, last, s, b), d);
            mb[s][b] = d;
            if (!last) begin
                chk(disp_valid === 1'b0, "R2 no early dispatch", disp_valid, 0);
            end else begin
                chk(disp_valid === 1'b1, "R3 dispatch", disp_valid, 1);
                chk(disp_slot === 2'(s), "R3 slot", disp_slot, s);
                chk(disp_len === 3'(n), "R3 len", disp_len, n);
                for (int k = 0; k < n; k++)
                    chk(disp_data[k*32 +: 32] === mb[s][k], "R3 beat", disp_data[k*32 +: 32], mb[s][k]);
                ex_busy[s] = 1;
            end
            if (b == 0) begin
                ex_done[s] = 0;
                check_status("R10 done cleared on reuse");
                if (last) chk(disp_valid === 1'b0, "R3 single pulse", disp_valid, 0);
            end
        end
    endtask

    initial begin
        rst = 1; bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
        res_valid = 0; res_slot = '0; res_data = '0;
        ex_busy = '0; ex_done = '0; ex_err = 0;
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 4; b++) mb[s][b] = '0;
            mr[s][0] = '0; mr[s][1] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        chk(disp_valid === 1'b0, "R1 disp_valid", disp_valid, 0);
        chk(bus_rvalid === 1'b0, "R1 rvalid", bus_rvalid, 0);
        check_status("R1 R9 status after reset");

        for (int it = 0; it < 4; it++) begin
            int n;
            n = it + 1;
            for (int s = 0; s < 4; s++) send_cmd(s, n, it);
            check_status("R4 R11 all busy");

            // drop: last-flagged write to a busy slot
            bwrite(mk(0, 1, it, 0), 32'hDEAD_0000 | it);
            chk(disp_valid === 1'b0, "R5 no dispatch on drop", disp_valid, 0);
            ex_err = 1;
            check_status("R6 error flag");

            for (int s = 3; s >= 0; s--) begin
                give_res(s, 32'h5000_0000 | (s << 12) | it, 32'h6000_0000 | (s << 12) | it);
                check_status("R7 result completes");
            end
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 4; w++) begin
                    logic [31:0] e;
                    e = (w < 2) ? mr[s][w] : 32'h0;
                    bread(mk(1, 0, s, w), rd);
                    chk(rd === e, "R8 result word", rd, e);
                end

            give_res(0, 32'hBAD0_0000, 32'hBAD1_0000);
            bread(mk(1, 0, 0, 0), rd);
            chk(rd === mr[0][0], "R7 idle result ignored", rd, mr[0][0]);

            bwrite(mk(1, 1, 1, 0), 32'hFEED_0000 | it);
            chk(disp_valid === 1'b0, "R12 no dispatch", disp_valid, 0);
            bread(mk(1, 0, 1, 0), rd);
            chk(rd === mr[1][0], "R12 result untouched", rd, mr[1][0]);
            check_status("R12 status untouched");
        end

        // dropped beat must not overwrite stored beat
        bwrite(mk(0, 0, 2, 0), 32'h1111_2222);
        bwrite(mk(0, 1, 2, 1), 32'h3333_4444);
        chk(disp_valid === 1'b1, "R3 dispatch", disp_valid, 1);
        bwrite(mk(0, 0, 2, 0), 32'h9999_9999);
        chk(disp_valid === 1'b0, "R5 no dispatch on drop", disp_valid, 0);
        ex_busy[2] = 1; ex_done[2] = 0;
        give_res(2, 32'h0, 32'h0);
        bwrite(mk(0, 1, 2, 1), 32'h5555_6666);
        chk(disp_valid === 1'b1, "R3 dispatch", disp_valid, 1);
        chk(disp_data[31:0] === 32'h1111_2222, "R5 held beat", disp_data[31:0], 32'h1111_2222);
        ex_busy[2] = 1; ex_done[2] = 0;
        check_status("R6 error still set");

        rst = 1;
        @(negedge clk);
        rst = 0;
        ex_busy = '0; ex_done = '0; ex_err = 0;
        check_status("R1 R6 reset clears");

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule